// File: doc/BRIEF.md
# Execution-Time Watchdog Channel

This block times one real-time task. A 16-bit counter counts down from a loaded budget at a selectable rate. It checks both bounds of the task's run time with that single counter. If the count reaches zero, the maximum allowed time has run out, and a sticky interrupt request is raised. It stays raised until the host acknowledges it. At any moment, the time already spent is the maximum constant minus the present count. A flag reports whether that time is still below the minimum constant, which means the task would be ending too early.

The rate comes from a shared divider that supplies four one-clock-wide tick pulses, for 1, 4, 16 and 64 µs at a 1 MHz base. A 3-bit control word picks one of these ticks and gates counting on or off. The host writes the control word, the counter and the two constants over a shared data-in bus, one load strobe each. It reads them back on a data-out bus through per-register output-enable strobes. Decoding of the host bus and the sequencing of commands sit outside this block.

Top module: `wdog_exec_chan`

## Requirements
- R1: After reset or a `clr_i` pulse: the control word is 000, the counter holds all ones, both constants are zero, and `irq_o` is low.
- R2: `ld_ctl_i` stores `din_i[2:0]` as the control word. Bit 2 is the run enable and bits 1:0 are the rate select. Reading it back returns the word in bits 2:0, with zeros above.
- R3: The counter drops by exactly one at a clock edge only when run is 1 and the tick that the rate select names is high on `ticks_i`. Select values 0, 1, 2 and 3 pick `ticks_i[0]`, `[1]`, `[2]` and `[3]`.
- R4: With run at 0, or with the selected tick low, the counter holds its value. Pulses on unselected ticks have no effect.
- R5: The counter stops at zero and never wraps to all ones.
- R6: `tc_o` is high exactly while the counter value is zero.
- R7: `irq_o` rises at the edge after `tc_o` is seen high. It then stays high until an edge where `ack_i` or `clr_i` is high; that edge clears it, even if the count is still zero.
- R8: `early_o` is 1 when (max constant − count) mod 2^16 is less than the min constant, and 0 otherwise.
- R9: Counter writes have a fixed priority: `clr_i`, then `cnt_rst_i` (sets all ones), then `ld_cnt_i` (loads `din_i`), then `ld_cnt_max_i` (copies the max constant), then a rate step.
- R10: `ld_max_i` and `ld_min_i` store `din_i` into the max and min constants, and their output enables read them back unchanged.
- R11: `dout_o` carries one source at a time, with priority counter, then control, then max, then min. When no output enable is high, `dout_o` is zero and `dout_en_o` is low; otherwise `dout_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous global clear to reset values |
| ticks_i | input | 4 | Shared divider pulses: 1, 4, 16, 64 µs |
| din_i | input | 16 | Shared data-in bus |
| ld_ctl_i | input | 1 | Load control word from din_i[2:0] |
| ld_cnt_i | input | 1 | Load counter from din_i |
| ld_cnt_max_i | input | 1 | Copy max constant into counter |
| ld_max_i | input | 1 | Load max constant |
| ld_min_i | input | 1 | Load min constant |
| cnt_rst_i | input | 1 | Return counter to all ones |
| oe_ctl_i | input | 1 | Drive control word on dout_o |
| oe_cnt_i | input | 1 | Drive counter on dout_o |
| oe_max_i | input | 1 | Drive max constant on dout_o |
| oe_min_i | input | 1 | Drive min constant on dout_o |
| ack_i | input | 1 | Acknowledge; clears irq_o |
| dout_o | output | 16 | Data-out bus value |
| dout_en_o | output | 1 | High when a source is driving dout_o |
| tc_o | output | 1 | Counter is zero |
| irq_o | output | 1 | Latched expiry request |
| early_o | output | 1 | Elapsed time below min constant |

## Verification
The rate path is driven with a table of control words and tick patterns. The patterns include the selected tick alone, only unselected ticks, all four ticks at once, and the run bit off with the selected tick present. Together they tell a correct tick selection apart from an off-by-one or inverted select, and show whether the enable is honoured. The bound check is tried with counts that put the elapsed time one below, exactly at, and well past the min constant. The expiry path walks the counter down to zero, keeps stepping once at zero, and acknowledges both while the count is still zero and after a reload. This separates a sticky request from a level copy of the terminal count, and shows whether the acknowledge takes priority.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
// Shared defaults and types for the execution-time watchdog channel.
// Assumes: consumers take widths as parameters defaulting to these values.
package wdog_pkg;
    localparam int DEF_CNT_W  = 16;
    localparam int DEF_PACE_W = 2;

    // Which register currently owns the data-out bus.
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_CNT  = 3'd1,
        SRC_CTL  = 3'd2,
        SRC_MAX  = 3'd3,
        SRC_MIN  = 3'd4
    } dout_src_e;
endpackage

// File: rtl/wdog_rate_sel.sv
`timescale 1ns/1ps
// Picks one divider tick by the rate select and gates it with run.
// Assumes: each tick is a one-clock-wide enable pulse from a shared divider.
module wdog_rate_sel #(
    parameter int PACE_W = 2,
    localparam int NUM_RATES = 1 << PACE_W
) (
    input  logic [NUM_RATES-1:0] ticks_i,
    input  logic [PACE_W-1:0]    pace_i,
    input  logic                 run_i,
    output logic                 step_o
);
    logic [NUM_RATES-1:0] hit;

    // One AND term per rate; the select matches exactly one index.
    for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
        assign hit[i] = ticks_i[i] && (pace_i == PACE_W'(i));
    end

    // Step only when enabled and the chosen rate pulses.
    assign step_o = run_i && (|hit);
endmodule

// File: rtl/wdog_down_cnt.sv
`timescale 1ns/1ps
// Down-counter with prioritised loads that holds at zero.
// Assumes: step_i is a single-cycle enable; all loads are synchronous.
module wdog_down_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             rst_cnt_i,
    input  logic             ld_din_i,
    input  logic [CNT_W-1:0] din_i,
    input  logic             ld_max_i,
    input  logic [CNT_W-1:0] max_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Counter update with clear > reset strobe > data load > max copy > step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '1;
        end else if (rst_cnt_i) begin
            cnt_q <= '1;
        end else if (ld_din_i) begin
            cnt_q <= din_i;
        end else if (ld_max_i) begin
            cnt_q <= max_i;
        end else if (step_i && !zero_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Terminal count decode.
    assign zero_o = (cnt_q == '0);
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/wdog_bound_chk.sv
`timescale 1ns/1ps
// Lower-bound compare and upper-bound request latch for one channel.
// Assumes: elapsed time is max minus count in modular arithmetic.
module wdog_bound_chk #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ack_i,
    input  logic             tc_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] max_i,
    input  logic [CNT_W-1:0] min_i,
    output logic             irq_o,
    output logic             early_o
);
    logic [CNT_W-1:0] elapsed;
    logic             irq_q;

    // Time spent since the budget was loaded, and the too-early compare.
    always_comb begin
        elapsed = max_i - cnt_i;
        early_o = (elapsed < min_i);
    end

    // Set/reset latch: clear wins, terminal count sets, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || ack_i) begin
            irq_q <= 1'b0;
        end else if (tc_i) begin
            irq_q <= 1'b1;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/wdog_exec_chan.sv
`timescale 1ns/1ps
// One execution-time watchdog channel: control word, max/min constants,
// prescaled down-counter, expiry request latch and too-early flag, with
// per-register load and output-enable strobes on shared buses.
// Assumes: the host raises at most the strobes it means; output enables
// are resolved by fixed priority so the bus never has two sources.
module wdog_exec_chan #(
    parameter int CNT_W  = wdog_pkg::DEF_CNT_W,
    parameter int PACE_W = wdog_pkg::DEF_PACE_W,
    localparam int NUM_RATES = 1 << PACE_W,
    localparam int CTL_W     = PACE_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic [NUM_RATES-1:0] ticks_i,
    input  logic [CNT_W-1:0]     din_i,
    input  logic                 ld_ctl_i,
    input  logic                 ld_cnt_i,
    input  logic                 ld_cnt_max_i,
    input  logic                 ld_max_i,
    input  logic                 ld_min_i,
    input  logic                 cnt_rst_i,
    input  logic                 oe_ctl_i,
    input  logic                 oe_cnt_i,
    input  logic                 oe_max_i,
    input  logic                 oe_min_i,
    input  logic                 ack_i,
    output logic [CNT_W-1:0]     dout_o,
    output logic                 dout_en_o,
    output logic                 tc_o,
    output logic                 irq_o,
    output logic                 early_o
);
    import wdog_pkg::*;

    logic [CTL_W-1:0] ctl_q;
    logic [CNT_W-1:0] max_q;
    logic [CNT_W-1:0] min_q;
    logic [CNT_W-1:0] cnt_val;
    logic             step_en;
    dout_src_e        src;

    // Control word: run bit on top, rate select below.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            ctl_q <= '0;
        end else if (ld_ctl_i) begin
            ctl_q <= din_i[CTL_W-1:0];
        end
    end

    // Maximum execution-time constant.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            max_q <= '0;
        end else if (ld_max_i) begin
            max_q <= din_i;
        end
    end

    // Minimum execution-time constant.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            min_q <= '0;
        end else if (ld_min_i) begin
            min_q <= din_i;
        end
    end

    wdog_rate_sel #(.PACE_W(PACE_W)) u_rate (
        .ticks_i (ticks_i),
        .pace_i  (ctl_q[PACE_W-1:0]),
        .run_i   (ctl_q[CTL_W-1]),
        .step_o  (step_en)
    );

    wdog_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_i),
        .rst_cnt_i (cnt_rst_i),
        .ld_din_i  (ld_cnt_i),
        .din_i     (din_i),
        .ld_max_i  (ld_cnt_max_i),
        .max_i     (max_q),
        .step_i    (step_en),
        .cnt_o     (cnt_val),
        .zero_o    (tc_o)
    );

    wdog_bound_chk #(.CNT_W(CNT_W)) u_bound (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .ack_i   (ack_i),
        .tc_i    (tc_o),
        .cnt_i   (cnt_val),
        .max_i   (max_q),
        .min_i   (min_q),
        .irq_o   (irq_o),
        .early_o (early_o)
    );

    // Resolve which register owns the data-out bus this cycle.
    always_comb begin
        if (oe_cnt_i)      src = SRC_CNT;
        else if (oe_ctl_i) src = SRC_CTL;
        else if (oe_max_i) src = SRC_MAX;
        else if (oe_min_i) src = SRC_MIN;
        else               src = SRC_NONE;
    end

    // Drive the selected register, zero when idle.
    always_comb begin
        dout_en_o = (src != SRC_NONE);
        case (src)
            SRC_CNT: dout_o = cnt_val;
            SRC_CTL: dout_o = {{(CNT_W-CTL_W){1'b0}}, ctl_q};
            SRC_MAX: dout_o = max_q;
            SRC_MIN: dout_o = min_q;
            default: dout_o = '0;
        endcase
    end
endmodule

// File: rtl/wdog_exec_chan_chk.sv
`timescale 1ns/1ps
// Property checker for the watchdog channel, bound to every instance.
// Assumes: it sees the top's ports and internal counter and control nets.
module wdog_exec_chan_chk #(
    parameter int CNT_W  = 16,
    parameter int PACE_W = 2,
    localparam int CTL_W = PACE_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             ack_i,
    input logic             cnt_rst_i,
    input logic             ld_cnt_i,
    input logic             ld_cnt_max_i,
    input logic             step_en,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CTL_W-1:0] ctl_q,
    input logic             tc_o,
    input logic             irq_o,
    input logic             oe_cnt_i,
    input logic             oe_ctl_i,
    input logic             oe_max_i,
    input logic             oe_min_i,
    input logic [CNT_W-1:0] dout_o,
    input logic             dout_en_o
);
    logic no_load;
    assign no_load = !clr_i && !cnt_rst_i && !ld_cnt_i && !ld_cnt_max_i;

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (no_load && step_en && cnt_val != '0) |=> cnt_val == $past(cnt_val) - 1'b1);

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (no_load && !step_en) |=> $stable(cnt_val));

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (no_load && cnt_val == '0) |=> cnt_val == '0);

    a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !ack_i && !clr_i) |=> irq_o);

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i && !clr_i) |=> irq_o);

    a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i || clr_i) |=> !irq_o);

    a_r1_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_val == '1 && ctl_q == '0 && !irq_o));

    a_r11_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_cnt_i && !oe_ctl_i && !oe_max_i && !oe_min_i) |-> (dout_o == '0 && !dout_en_o));
endmodule

bind wdog_exec_chan wdog_exec_chan_chk #(.CNT_W(CNT_W), .PACE_W(PACE_W)) u_chk (.*);

// File: tb/sim_wdog_exec_chan.sv
`timescale 1ns/1ps
// Self-checking bench for the watchdog channel.
module sim_wdog_exec_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic [3:0]  ticks_i = '0;
    logic [15:0] din_i = '0;
    logic        ld_ctl_i = 0, ld_cnt_i = 0, ld_cnt_max_i = 0, ld_max_i = 0, ld_min_i = 0;
    logic        cnt_rst_i = 0, oe_ctl_i = 0, oe_cnt_i = 0, oe_max_i = 0, oe_min_i = 0;
    logic        ack_i = 0;
    logic [15:0] dout_o;
    logic        dout_en_o, tc_o, irq_o, early_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    wdog_exec_chan u0 (.*);

    // Vector: {ctl[2:0], ticks[3:0], expect_decrement}
    localparam logic [7:0] VEC [10] = '{
        {3'b100, 4'b0001, 1'b1},
        {3'b100, 4'b0010, 1'b0},
        {3'b101, 4'b0010, 1'b1},
        {3'b101, 4'b0001, 1'b0},
        {3'b110, 4'b0100, 1'b1},
        {3'b111, 4'b1000, 1'b1},
        {3'b111, 4'b0111, 1'b0},
        {3'b011, 4'b1000, 1'b0},
        {3'b000, 4'b1111, 1'b0},
        {3'b110, 4'b1111, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Let one clock edge pass, then settle inputs to idle just after it.
    task automatic step();
        @(posedge clk);
        #1;
        {ld_ctl_i, ld_cnt_i, ld_cnt_max_i, ld_max_i, ld_min_i, cnt_rst_i, ack_i, clr_i} = '0;
        ticks_i = '0;
    endtask

    task automatic rd(input int which, output logic [15:0] v);
        oe_cnt_i = (which == 0); oe_ctl_i = (which == 1);
        oe_max_i = (which == 2); oe_min_i = (which == 3);
        #0.2;
        v = dout_o;
        {oe_cnt_i, oe_ctl_i, oe_max_i, oe_min_i} = '0;
        #0.1;
    endtask

    task automatic wr(input int which, input logic [15:0] v);
        din_i = v;
        case (which)
            0: ld_cnt_i = 1;
            1: ld_ctl_i = 1;
            2: ld_max_i = 1;
            default: ld_min_i = 1;
        endcase
        step();
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1 reset state
        rd(0, v); chk("R1 count after reset", v, 16'hFFFF);
        rd(1, v); chk("R1 ctl after reset", v, 16'h0000);
        rd(2, v); chk("R1 max after reset", v, 16'h0000);
        chk("R1 irq after reset", {15'b0, irq_o}, 16'h0);

        // R2 control load keeps low three bits
        wr(1, 16'hFFFD);
        rd(1, v); chk("R2 ctl readback", v, 16'h0005);

        // R10 constants
        wr(2, 16'h1234); rd(2, v); chk("R10 max readback", v, 16'h1234);
        wr(3, 16'h0010); rd(3, v); chk("R10 min readback", v, 16'h0010);

        // R11 priority and idle bus
        wr(0, 16'h00AA);
        oe_cnt_i = 1; oe_ctl_i = 1; oe_max_i = 1; #0.2;
        chk("R11 counter wins", dout_o, 16'h00AA);
        oe_cnt_i = 0; #0.2;
        chk("R11 ctl next", dout_o, 16'h0005);
        oe_ctl_i = 0; oe_min_i = 1; #0.2;
        chk("R11 max over min", dout_o, 16'h1234);
        oe_max_i = 0; oe_min_i = 0; #0.2;
        chk("R11 idle bus", {dout_o[14:0], dout_en_o}, 16'h0000);

        // R3 / R4 table of rate patterns
        for (int i = 0; i < 10; i++) begin
            wr(0, 16'd1000);
            wr(1, {13'b0, VEC[i][7:5]});
            ticks_i = VEC[i][4:1];
            step();
            rd(0, v);
            chk(VEC[i][0] ? "R3 step on selected tick" : "R4 hold without step",
                v, VEC[i][0] ? 16'd999 : 16'd1000);
        end

        // R9 load priorities
        wr(1, 16'h0000);
        wr(2, 16'd100);
        din_i = 16'd5; ld_cnt_i = 1; ld_cnt_max_i = 1; step();
        rd(0, v); chk("R9 din over max copy", v, 16'd5);
        din_i = 16'd7; ld_cnt_i = 1; cnt_rst_i = 1; step();
        rd(0, v); chk("R9 reset strobe over din", v, 16'hFFFF);
        ld_cnt_max_i = 1; step();
        rd(0, v); chk("R9 copy from max", v, 16'd100);

        // R8 too-early boundary: max=100, min=10
        wr(3, 16'd10);
        chk("R8 elapsed 0", {15'b0, early_o}, 16'h1);
        wr(0, 16'd91); chk("R8 elapsed 9", {15'b0, early_o}, 16'h1);
        wr(0, 16'd90); chk("R8 elapsed 10", {15'b0, early_o}, 16'h0);
        wr(0, 16'd50); chk("R8 elapsed 50", {15'b0, early_o}, 16'h0);

        // R5 / R6 / R7 expiry path
        wr(0, 16'd2);
        wr(1, 16'h0004);
        ticks_i = 4'b0001; step();
        chk("R6 tc low at 1", {15'b0, tc_o}, 16'h0);
        ticks_i = 4'b0001; step();
        chk("R6 tc high at 0", {15'b0, tc_o}, 16'h1);
        chk("R7 irq not yet", {15'b0, irq_o}, 16'h0);
        ticks_i = 4'b0001; step();
        rd(0, v); chk("R5 no wrap", v, 16'h0000);
        chk("R7 irq set", {15'b0, irq_o}, 16'h1);
        ack_i = 1; step();
        chk("R7 ack clears", {15'b0, irq_o}, 16'h0);
        step();
        chk("R7 re-set while zero", {15'b0, irq_o}, 16'h1);
        wr(0, 16'd50);
        chk("R6 tc low after reload", {15'b0, tc_o}, 16'h0);
        step();
        chk("R7 sticky after reload", {15'b0, irq_o}, 16'h1);
        ack_i = 1; step();
        step();
        chk("R7 stays clear", {15'b0, irq_o}, 16'h0);

        // R1 global clear
        wr(0, 16'd0);
        step();
        clr_i = 1; step();
        rd(0, v); chk("R1 clear count", v, 16'hFFFF);
        rd(1, v); chk("R1 clear ctl", v, 16'h0000);
        rd(2, v); chk("R1 clear max", v, 16'h0000);
        chk("R1 clear irq", {15'b0, irq_o}, 16'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule